// File: doc/BRIEF.md
# Disk Controller Phase Handshake Sequencer

This block sequences the phases that a host sees when it drives a floppy-style disk controller through a single data port and a main status byte. The host writes command bytes one at a time. The block holds back the request-for-master flag for one cycle while it latches each byte. It reads the command length and the result length from a small internal table, keyed by the first byte. When the last command byte arrives, it starts the execution engine.

The execution engine reports completion with one pulse. During that pulse a parallel bus carries every result byte at once. The block captures those bytes and raises an interrupt to begin the result phase. It then hands the bytes out in order on host reads. When the host has drained the final byte, the block returns to the idle state, and only then accepts a new command.

Reads that the status flags do not permit return the status byte and change nothing. Writes made during the result phase are dropped and set a sticky error flag.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset, RQM=1, DIO=0, CB=0, irq=0, wr_err=0 and exec_start=0.
- R2: The first command byte written in idle sets CB. CB stays 1 through the command, execution and result phases, and clears only when the last result byte has been read.
- R3: In the cycle after every accepted write, RQM=0. One cycle later, if more command bytes are due, RQM=1 and DIO=0.
- R4: The command and result byte counts come from bits [4:0] of the first byte: 0x04 gives 2 and 1, 0x06 gives 9 and 7, 0x08 gives 1 and 2, 0x0A gives 2 and 7, and any other value gives 1 and 1. In the cycle after the last command byte, exec_start is 1 for exactly one cycle and exec_op equals the first byte. After that, RQM=0, DIO=0 and CB=1 until the engine finishes.
- R5: An exec_done pulse during execution gives irq=1, RQM=1 and DIO=1 on the next cycle. An exec_done pulse at any other time is ignored.
- R6: Result byte k is taken from exec_result bits [8k+7:8k] when exec_done is sampled. Reads during the result phase return the bytes in order 0, 1, … on host_rdata, which is valid before the read strobe edge.
- R7: The interrupt clears on the cycle after the first result-byte read.
- R8: After the last result byte is read, RQM=1, DIO=0 and CB=0 on the next cycle, and a new command is accepted.
- R9: While RQM and DIO are not both 1, host_rdata shows the status byte (RQM in bit 7, DIO in bit 6, CB in bit 4, all other bits 0). A read in that state changes nothing.
- R10: A write during the result phase is ignored and sets the sticky wr_err flag, which only reset clears. A write while RQM=0 is ignored and does not set wr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr | input | 1 | Host data-port write strobe |
| host_rd | input | 1 | Host data-port read strobe |
| host_wdata | input | 8 | Command byte from the host |
| host_rdata | output | 8 | Result byte in the result phase, otherwise the status byte |
| rqm | output | 1 | Request for master: data port ready |
| dio | output | 1 | Direction: 1 = controller to host |
| cb | output | 1 | Controller busy with a command |
| irq | output | 1 | Interrupt marking the result phase |
| wr_err | output | 1 | Sticky flag for a write during the result phase |
| exec_start | output | 1 | One-cycle pulse: command complete, execution begins |
| exec_op | output | 8 | First byte of the current command |
| exec_done | input | 1 | Execution engine finished |
| exec_result | input | 56 | Result bytes, byte k at bits [8k+7:8k] |

## Verification
Two functions can fall in the same cycle. The host can read the final result byte and write the data port in the same cycle. This pairs the return to idle with the result-phase write rejection. The bench asserts both strobes on that last read and then expects two things: the idle status with CB=0, meaning no new command was started, and wr_err set. A second overlap is an exec_done pulse arriving while the host also writes during execution. There the write must vanish, with no error, while the result phase still opens on schedule.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_LATCH,
    PH_EXEC,
    PH_RES
  } phase_t;

  localparam int STAT_RQM_BIT = 7;
  localparam int STAT_DIO_BIT = 6;
  localparam int STAT_CB_BIT  = 4;

endpackage

// File: rtl/fdc_cmd_table.sv
module fdc_cmd_table #(
  parameter int CLEN_W = 4,
  parameter int RLEN_W = 3
) (
  input  logic [7:0]        lead_byte,
  output logic [CLEN_W-1:0] cmd_len,
  output logic [RLEN_W-1:0] res_len
);

  always_comb begin
    unique case (lead_byte[4:0])
      5'h04:   begin cmd_len = CLEN_W'(2); res_len = RLEN_W'(1); end
      5'h06:   begin cmd_len = CLEN_W'(9); res_len = RLEN_W'(7); end
      5'h08:   begin cmd_len = CLEN_W'(1); res_len = RLEN_W'(2); end
      5'h0A:   begin cmd_len = CLEN_W'(2); res_len = RLEN_W'(7); end
      default: begin cmd_len = CLEN_W'(1); res_len = RLEN_W'(1); end
    endcase
  end

endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
  parameter int MAX_RES = 7,
  parameter int IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MAX_RES*8-1:0] din,
  input  logic [IDX_W-1:0]     idx,
  output logic [7:0]           dout
);

  logic [7:0] slot_q [MAX_RES];

  for (genvar g = 0; g < MAX_RES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (load) begin
        slot_q[g] <= din[g*8 +: 8];
      end
    end
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < MAX_RES; k++) begin
      if (idx == IDX_W'(k)) dout = slot_q[k];
    end
  end

endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
  import fdc_seq_pkg::*;
#(
  parameter int CLEN_W = 4,
  parameter int RLEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  input  logic              exec_done,
  input  logic [CLEN_W-1:0] tbl_cmd_len,
  input  logic [RLEN_W-1:0] tbl_res_len,
  output phase_t            phase,
  output logic [RLEN_W-1:0] res_idx,
  output logic [7:0]        lead_byte,
  output logic              irq,
  output logic              wr_err,
  output logic              load_res,
  output logic              exec_start
);

  phase_t            phase_q, phase_d;
  logic [CLEN_W-1:0] got_q, got_d, need_q, need_d;
  logic [RLEN_W-1:0] rneed_q, rneed_d, ridx_q, ridx_d;
  logic [7:0]        lead_q, lead_d;
  logic              irq_q, irq_d, err_q, err_d;

  always_comb begin
    phase_d  = phase_q;
    got_d    = got_q;
    need_d   = need_q;
    rneed_d  = rneed_q;
    ridx_d   = ridx_q;
    lead_d   = lead_q;
    irq_d    = irq_q;
    err_d    = err_q;
    load_res = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (host_wr) begin
          lead_d  = host_wdata;
          need_d  = tbl_cmd_len;
          rneed_d = tbl_res_len;
          got_d   = CLEN_W'(1);
          phase_d = PH_LATCH;
        end
      end
      PH_CMD: begin
        if (host_wr) begin
          got_d   = got_q + CLEN_W'(1);
          phase_d = PH_LATCH;
        end
      end
      PH_LATCH: begin
        phase_d = (got_q >= need_q) ? PH_EXEC : PH_CMD;
      end
      PH_EXEC: begin
        if (exec_done) begin
          load_res = 1'b1;
          ridx_d   = '0;
          irq_d    = 1'b1;
          phase_d  = PH_RES;
        end
      end
      PH_RES: begin
        if (host_wr) err_d = 1'b1;
        if (host_rd) begin
          irq_d  = 1'b0;
          ridx_d = ridx_q + RLEN_W'(1);
          if (ridx_q == rneed_q - RLEN_W'(1)) phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      got_q   <= '0;
      need_q  <= '0;
      rneed_q <= '0;
      ridx_q  <= '0;
      lead_q  <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      got_q   <= got_d;
      need_q  <= need_d;
      rneed_q <= rneed_d;
      ridx_q  <= ridx_d;
      lead_q  <= lead_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  assign phase      = phase_q;
  assign res_idx    = ridx_q;
  assign lead_byte  = lead_q;
  assign irq        = irq_q;
  assign wr_err     = err_q;
  assign exec_start = (phase_q == PH_LATCH) && (got_q >= need_q);

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int MAX_CMD = 9,
  parameter int MAX_RES = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 rqm,
  output logic                 dio,
  output logic                 cb,
  output logic                 irq,
  output logic                 wr_err,
  output logic                 exec_start,
  output logic [7:0]           exec_op,
  input  logic                 exec_done,
  input  logic [MAX_RES*8-1:0] exec_result
);

  localparam int CLEN_W = $clog2(MAX_CMD + 1);
  localparam int RLEN_W = $clog2(MAX_RES + 1);

  phase_t            phase;
  logic [CLEN_W-1:0] tbl_cmd_len;
  logic [RLEN_W-1:0] tbl_res_len;
  logic [RLEN_W-1:0] res_idx;
  logic              load_res;
  logic [7:0]        res_byte;
  logic [7:0]        stat_byte;

  fdc_cmd_table #(.CLEN_W(CLEN_W), .RLEN_W(RLEN_W)) i_table (
    .lead_byte (host_wdata),
    .cmd_len   (tbl_cmd_len),
    .res_len   (tbl_res_len)
  );

  fdc_phase_fsm #(.CLEN_W(CLEN_W), .RLEN_W(RLEN_W)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .exec_done   (exec_done),
    .tbl_cmd_len (tbl_cmd_len),
    .tbl_res_len (tbl_res_len),
    .phase       (phase),
    .res_idx     (res_idx),
    .lead_byte   (exec_op),
    .irq         (irq),
    .wr_err      (wr_err),
    .load_res    (load_res),
    .exec_start  (exec_start)
  );

  fdc_result_buf #(.MAX_RES(MAX_RES), .IDX_W(RLEN_W)) i_rbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_res),
    .din   (exec_result),
    .idx   (res_idx),
    .dout  (res_byte)
  );

  assign rqm = (phase == PH_IDLE) || (phase == PH_CMD) || (phase == PH_RES);
  assign dio = (phase == PH_RES);
  assign cb  = (phase != PH_IDLE);

  always_comb begin
    stat_byte               = '0;
    stat_byte[STAT_RQM_BIT] = rqm;
    stat_byte[STAT_DIO_BIT] = dio;
    stat_byte[STAT_CB_BIT]  = cb;
  end

  assign host_rdata = dio ? res_byte : stat_byte;

endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic host_rd,
  input logic exec_done,
  input logic rqm,
  input logic dio,
  input logic cb,
  input logic irq,
  input logic wr_err,
  input logic exec_start
);

  AST_RQM_DROP_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && rqm && !dio) |=> !rqm);  // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> (!exec_start && !rqm && !dio && cb));  // R4

  AST_IRQ_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rqm && dio && cb));  // R5

  AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && host_rd) |=> !irq);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cb |-> (rqm && !dio && !irq));  // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);  // R10

  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && rqm && !dio) |=> (rqm && !dio && $stable(cb)));  // R9

endmodule

bind fdc_phase_seq fdc_phase_seq_chk i_chk (.*);

// File: tb/test_fdc_phase_seq.sv
module test_fdc_phase_seq;

  localparam int RW = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          rqm, dio, cb, irq, wr_err, exec_start;
  logic [7:0]    exec_op;
  logic          exec_done = 1'b0;
  logic [RW-1:0] exec_result = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  fdc_phase_seq i_fdc_phase_seq (
    .clk, .rst_n, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .rqm, .dio, .cb, .irq, .wr_err, .exec_start, .exec_op,
    .exec_done, .exec_result
  );

  function automatic int exp_clen(input logic [7:0] b);
    case (b[4:0])
      5'h04: return 2;
      5'h06: return 9;
      5'h08: return 1;
      5'h0A: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_rlen(input logic [7:0] b);
    case (b[4:0])
      5'h04: return 1;
      5'h06: return 7;
      5'h08: return 2;
      5'h0A: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input logic r, input logic d, input logic c);
    return {r, d, 1'b0, c, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; exec_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {rqm, dio, cb}, 3'b100);
    chk("R1 irq/err/start", {irq, wr_err, exec_start}, 3'b000);
    chk("R9 idle status byte", host_rdata, exp_stat(1'b1, 1'b0, 1'b0));
  endtask

  // mode: 0 plain, 1 write in result phase, 2 write with last read
  task automatic run_cmd(input logic [7:0] op, input bit spur, input bit poke_exec, input int mode);
    int cl = exp_clen(op);
    int rl = exp_rlen(op);
    logic [RW-1:0] rv;
    for (int i = 0; i < cl; i++) begin
      host_wdata = (i == 0) ? op : 8'($urandom);
      host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      chk("R3 rqm low after write", rqm, 1'b0);
      if (i == 0) chk("R2 cb set", cb, 1'b1);
      if (i == cl - 1) begin
        chk("R4 exec_start", exec_start, 1'b1);
        chk("R4 exec_op", exec_op, op);
      end else begin
        chk("R4 no early start", exec_start, 1'b0);
      end
      @(negedge clk);
      if (i < cl - 1) begin
        chk("R3 ready again", {rqm, dio}, 2'b10);
        if (spur) begin
          chk("R9 status in command", host_rdata, exp_stat(1'b1, 1'b0, 1'b1));
          host_rd = 1'b1;
          @(negedge clk);
          host_rd = 1'b0;
          chk("R9 read no effect", {rqm, dio, cb}, 3'b101);
        end
      end
    end
    chk("R4 exec status", {rqm, dio, cb, exec_start}, 4'b0010);
    chk("R9 status in exec", host_rdata, exp_stat(1'b0, 1'b0, 1'b1));
    rv = RW'({$urandom(), $urandom()});
    exec_result = rv;
    exec_done = 1'b1;
    if (poke_exec) begin
      host_wr = 1'b1;
      host_wdata = 8'h08;
    end
    @(negedge clk);
    exec_done = 1'b0;
    host_wr = 1'b0;
    exec_result = ~rv;
    chk("R5 irq", irq, 1'b1);
    chk("R5 result status", {rqm, dio, cb}, 3'b111);
    if (poke_exec) chk("R10 write at rqm=0 no err", wr_err, 1'b0);
    for (int k = 0; k < rl; k++) begin
      chk("R6 result byte", host_rdata, rv[8*k +: 8]);
      if (mode == 1 && k == 0) begin
        host_wr = 1'b1;
        host_wdata = 8'h06;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R10 err set", wr_err, 1'b1);
        chk("R10 write ignored", {rqm, dio, cb}, 3'b111);
        chk("R10 byte kept", host_rdata, rv[7:0]);
      end
      host_rd = 1'b1;
      if (mode == 2 && k == rl - 1) begin
        host_wr = 1'b1;
        host_wdata = 8'h08;
      end
      @(negedge clk);
      host_rd = 1'b0;
      host_wr = 1'b0;
      if (k == 0) chk("R7 irq cleared", irq, 1'b0);
      if (k < rl - 1) chk("R6 still result", {rqm, dio}, 2'b11);
    end
    chk("R8 back to idle", {rqm, dio, cb}, 3'b100);
    if (mode == 2) chk("R10 err on coincident write", wr_err, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] ops [5];
    void'($urandom(32'd7351));
    ops[0] = 8'h04; ops[1] = 8'h06; ops[2] = 8'h08; ops[3] = 8'h0A; ops[4] = 8'h1F;
    do_reset();

    // R5: exec_done outside execution ignored
    @(negedge clk);
    exec_done = 1'b1;
    exec_result = '1;
    @(negedge clk);
    exec_done = 1'b0;
    chk("R5 done ignored in idle", {rqm, dio, cb, irq}, 4'b1000);

    // R9: read in idle
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R9 idle read no effect", {rqm, dio, cb}, 3'b100);

    run_cmd(8'h08, 1'b0, 1'b0, 0);
    run_cmd(8'hC6, 1'b1, 1'b0, 0);
    run_cmd(8'h0A, 1'b0, 1'b1, 0);
    run_cmd(8'h13, 1'b0, 1'b0, 0);
    chk("R10 no err so far", wr_err, 1'b0);

    for (int n = 0; n < 40; n++) begin
      logic [7:0] op;
      op = {3'($urandom), ops[$urandom % 5][4:0]};
      if (($urandom % 5) == 4) op[4:0] = 5'($urandom);
      run_cmd(op, 1'($urandom), 1'($urandom), 0);
    end

    run_cmd(8'h04, 1'b0, 1'b0, 1);
    do_reset();
    run_cmd(8'h08, 1'b0, 1'b0, 2);
    run_cmd(8'h04, 1'b0, 1'b0, 0);
    finish_up();
  end

endmodule